// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous requester and an external 128K x 8 asynchronous static RAM. A request carries an address, a direction bit and, for writes, one data byte. The block accepts it through a ready/valid handshake and then plays out the strobe pattern the memory expects. The memory interface has a 17-bit address, a pair of chip selects of opposite polarity, an active-low output enable, an active-low write enable, and a split data bus: output byte, drive enable and input byte.

Every strobe phase lasts a whole number of clock cycles. Each count is worked out at elaboration time from nanosecond minimums and a clock-period parameter, rounding up. Output enable stays high for the whole of every write, so the memory's drivers never face the controller's drivers and the plain minimum write pulse applies. Read data is returned with a single-cycle valid pulse. The end of a write is reported with a single-cycle done pulse.

The state machine has six states:
- `ST_IDLE`: deselected and ready.
- `ST_RD_ACCESS`: selected with output enable low.
- `ST_RD_TAIL`: selected, padding to the read cycle time.
- `ST_WR_PULSE`: write enable low with data driven.
- `ST_WR_HOLD`: one cycle with write enable high and data still driven.
- `ST_WR_TAIL`: selected, padding to the write cycle time.

The transitions are:
- `ST_IDLE` moves to `ST_RD_ACCESS` or `ST_WR_PULSE` when a request is accepted.
- `ST_RD_ACCESS` moves to `ST_RD_TAIL` when padding is needed, or else to `ST_IDLE`.
- `ST_WR_PULSE` moves to `ST_WR_HOLD`.
- `ST_WR_HOLD` moves to `ST_WR_TAIL` when padding is needed, or else to `ST_IDLE`.
- Both tail states return to `ST_IDLE`.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held low, and afterwards until the first request, the chip selects are inactive (mem_cs1_n_o=1, mem_cs2_o=0). Both strobes are high, mem_dq_oe_o=0, req_ready_o=1, and rd_valid_o=0 and wr_done_o=0.
- R2: The chip selects always move together. mem_cs1_n_o is 0 exactly when mem_cs2_o is 1, and that is the case exactly when req_ready_o is 0.
- R3: A read holds mem_oe_n_o low and mem_we_n_o high for AA_CYC consecutive cycles. mem_dq_i is sampled at the clock edge that ends the last of those cycles. rd_valid_o is then high for exactly one cycle with rd_data_o equal to the byte stored at the address.
- R4: A write holds mem_we_n_o low for WP_CYC consecutive cycles and mem_oe_n_o high throughout. mem_dq_oe_o is high during the pulse and for exactly one cycle after it, and mem_dq_o carries the request byte unchanged over that span.
- R5: From acceptance to the return to idle, mem_addr_o equals the accepted address and does not change.
- R6: req_ready_o is high only in idle, and a request is taken at a clock edge where req_valid_i and req_ready_o are both 1. The next acceptance comes no sooner than max(AA_CYC,RC_CYC)+1 cycles after a read, and no sooner than max(WP_CYC+1,WC_CYC)+1 cycles after a write.
- R7: Each write produces exactly one wr_done_o pulse, one cycle long, in the cycle after the write's last busy cycle.
- R8: Each phase count is the nanosecond minimum divided by CLK_NS and rounded up. AA_CYC is computed from the address access time and RC_CYC and WC_CYC from the cycle times. WP_CYC is the largest of the rounded write-pulse, address-to-end-of-write and data-setup minimums. With the defaults (5 ns clock; 20/20/20/15/15/9 ns) these are 4, 4, 4 and 3.
- R9: The controller never drives the data bus (mem_dq_oe_o=1) while mem_oe_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request will be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rd_valid_o | output | 1 | One-cycle read data valid pulse |
| rd_data_o | output | 8 | Read byte |
| wr_done_o | output | 1 | One-cycle write complete pulse |
| mem_addr_o | output | 17 | Memory address |
| mem_cs1_n_o | output | 1 | Chip select, active low |
| mem_cs2_o | output | 1 | Chip select, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe_o | output | 1 | Tri-state enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The bench keeps the request line raised while the controller is busy, so a controller that took requests early would show too short a gap between acceptances. The memory model returns junk until the address has aged the full access count. A controller that sampled one cycle early would therefore return the wrong byte, and the model also counts a write pulse that is short, a missing hold cycle, or an address that moves mid-pulse. Read-after-write to the same address, reads of never-written locations, and the top address 0x1FFFF catch dropped commits and truncated address bits. A controller that ended data drive with the pulse, or that let output enable fall during a write, trips the drive-span and contention checks.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TAIL,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_TAIL
    } ctrl_state_e;

    // round a nanosecond minimum up to whole clock cycles
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sample_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= sample_i;
            if (sample_i) begin
                data_o <= din_i;
            end
        end
    end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 5,
    parameter int T_AA_NS  = 20,
    parameter int T_RC_NS  = 20,
    parameter int T_WC_NS  = 20,
    parameter int T_WP_NS  = 15,
    parameter int T_AW_NS  = 15,
    parameter int T_DW_NS  = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wr_done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs1_n_o,
    output logic              mem_cs2_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // phase lengths in cycles (R8)
    localparam int AA_CYC      = imax(1, ns_to_cyc(T_AA_NS, CLK_NS));
    localparam int RC_CYC      = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int WC_CYC      = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int WP_CYC      = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                     imax(ns_to_cyc(T_AW_NS, CLK_NS),
                                          ns_to_cyc(T_DW_NS, CLK_NS))));
    localparam int RD_TAIL_CYC = (RC_CYC > AA_CYC) ? RC_CYC - AA_CYC : 0;
    localparam int WR_TAIL_CYC = (WC_CYC > WP_CYC + 1) ? WC_CYC - WP_CYC - 1 : 0;
    localparam int MAX_LEN     = imax(imax(AA_CYC, WP_CYC), imax(RD_TAIL_CYC, WR_TAIL_CYC));
    localparam int CNT_W       = $clog2(MAX_LEN + 1);

    ctrl_state_e      state_q, state_d;
    logic             tmr_load, tmr_last;
    logic [CNT_W-1:0] tmr_len;
    logic             accept, sample_rd, write_end;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic             done_q;

    assign accept = req_valid_i && (state_q == ST_IDLE);

    // next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    tmr_load = 1'b1;
                    if (req_write_i) begin
                        state_d = ST_WR_PULSE;
                        tmr_len = CNT_W'(WP_CYC);
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_len = CNT_W'(AA_CYC);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_last) begin
                    if (RD_TAIL_CYC != 0) begin
                        state_d  = ST_RD_TAIL;
                        tmr_load = 1'b1;
                        tmr_len  = CNT_W'(RD_TAIL_CYC);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_RD_TAIL: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(1);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_last) begin
                    if (WR_TAIL_CYC != 0) begin
                        state_d  = ST_WR_TAIL;
                        tmr_load = 1'b1;
                        tmr_len  = CNT_W'(WR_TAIL_CYC);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WR_TAIL: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        req_ready_o = (state_q == ST_IDLE);
        mem_cs1_n_o = (state_q == ST_IDLE);
        mem_cs2_o   = (state_q != ST_IDLE);
        mem_oe_n_o  = (state_q != ST_RD_ACCESS);
        mem_we_n_o  = (state_q != ST_WR_PULSE);
        mem_dq_oe_o = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
        sample_rd   = (state_q == ST_RD_ACCESS) && tmr_last;
        write_end   = ((state_q == ST_WR_HOLD) || (state_q == ST_WR_TAIL))
                      && (state_d == ST_IDLE);
    end

    // request latch and done pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= write_end;
            if (accept) begin
                addr_q  <= req_addr_i;
                wdata_q <= req_wdata_i;
            end
        end
    end

    assign mem_addr_o = addr_q;
    assign mem_dq_o   = wdata_q;
    assign wr_done_o  = done_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (sample_rd),
        .din_i    (mem_dq_i),
        .valid_o  (rd_valid_o),
        .data_o   (rd_data_o)
    );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int WP_CYC = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              rd_valid_o,
    input logic              wr_done_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_cs1_n_o,
    input logic              mem_cs2_o,
    input logic              mem_oe_n_o,
    input logic              mem_we_n_o,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe_o
);
    logic [7:0] we_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          we_run_q <= '0;
        else if (!mem_we_n_o) we_run_q <= we_run_q + 8'd1;
        else                  we_run_q <= '0;
    end

    p_cs_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_cs1_n_o == !mem_cs2_o);

    p_idle_deselect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> mem_cs1_n_o);

    p_rd_after_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> $past(!mem_oe_n_o));

    p_rd_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |=> !rd_valid_o);

    p_wr_oe_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_we_n_o |-> (mem_oe_n_o && mem_dq_oe_o));

    p_hold_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_n_o) |-> mem_dq_oe_o);

    p_data_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

    p_addr_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_ready_o && $past(!req_ready_o)) |-> $stable(mem_addr_o));

    p_accept_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_done_o |=> !wr_done_o);

    p_wp_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_n_o) |-> (we_run_q >= 8'(WP_CYC)));

    p_no_contention_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_dq_oe_o |-> mem_oe_n_o);
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WP_CYC (WP_CYC)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .rd_valid_o  (rd_valid_o),
    .wr_done_o   (wr_done_o),
    .mem_addr_o  (mem_addr_o),
    .mem_cs1_n_o (mem_cs1_n_o),
    .mem_cs2_o   (mem_cs2_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_async_model.sv
module sram_async_model #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 8,
    parameter int AA_CYC = 4,
    parameter int WP_CYC = 3
) (
    input  logic              clk_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              din_oe_i,
    output logic [DATA_W-1:0] dout_o,
    output logic [15:0]       viol_o
);
    logic [DATA_W-1:0] mem [1 << MEM_AW];
    logic              sel, reading, writing, bad;
    logic [7:0]        age_q, wcnt_q;
    logic [ADDR_W-1:0] last_addr_q, waddr_q;
    logic              prev_read_q;
    logic [DATA_W-1:0] wdata_q;

    initial begin
        for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = DATA_W'(i) ^ DATA_W'(8'h5A);
        viol_o = '0;
        age_q = '0; wcnt_q = '0; prev_read_q = 1'b0;
        last_addr_q = '0; waddr_q = '0; wdata_q = '0;
    end

    assign sel     = !cs1_n_i && cs2_i;
    assign reading = sel && we_n_i && !oe_n_i;
    assign writing = sel && !we_n_i;
    assign dout_o  = (reading && age_q >= 8'(AA_CYC - 1)) ? mem[addr_i[MEM_AW-1:0]]
                                                           : DATA_W'(8'hEE);

    always_comb begin
        bad = 1'b0;
        if (din_oe_i && reading) bad = 1'b1;
        if (writing) begin
            if (wcnt_q != 0 && addr_i != waddr_q) bad = 1'b1;
            if (!din_oe_i || !oe_n_i) bad = 1'b1;
        end else if (wcnt_q != 0) begin
            if (wcnt_q < 8'(WP_CYC)) bad = 1'b1;
            if (!din_oe_i || din_i != wdata_q) bad = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        viol_o      <= viol_o + {15'd0, bad};
        prev_read_q <= reading;
        last_addr_q <= addr_i;
        if (!reading)                               age_q <= '0;
        else if (prev_read_q && addr_i == last_addr_q) age_q <= (age_q == 8'hFF) ? age_q : age_q + 8'd1;
        else                                        age_q <= 8'd1;
        if (writing) begin
            if (wcnt_q == 0) waddr_q <= addr_i;
            wcnt_q  <= wcnt_q + 8'd1;
            wdata_q <= din_i;
        end else if (wcnt_q != 0) begin
            mem[waddr_q[MEM_AW-1:0]] <= wdata_q;
            wcnt_q <= '0;
        end
    end
endmodule

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/100ps
module test_sram_strobe_ctrl;
    localparam int CLK = 5;
    // expected counts, rounded up independently (R8)
    localparam int E_AA = (20 + CLK - 1) / CLK;
    localparam int E_RC = (20 + CLK - 1) / CLK;
    localparam int E_WC = (20 + CLK - 1) / CLK;
    localparam int E_WP = (15 + CLK - 1) / CLK;
    localparam int E_RD_GAP = ((E_AA > E_RC) ? E_AA : E_RC) + 1;
    localparam int E_WR_GAP = ((E_WP + 1 > E_WC) ? E_WP + 1 : E_WC) + 1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid, wr_done;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        cs1_n, cs2, oe_n, we_n, dq_oe;
    logic [7:0]  dq_o, dq_i;
    logic [15:0] viol;

    int checks = 0, errors = 0, cycle = 0;
    logic [7:0] exp_q[$];
    logic [7:0] shadow[int];
    int  writes_issued = 0, done_seen = 0;
    logic [16:0] cur_addr = '0;
    logic [7:0]  cur_wdata = '0;
    int  last_acc = -100;
    logic last_wr = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    sram_strobe_ctrl i_sram_strobe_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .wr_done_o(wr_done),
        .mem_addr_o(mem_addr), .mem_cs1_n_o(cs1_n), .mem_cs2_o(cs2),
        .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_dq_o(dq_o),
        .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
    );

    sram_async_model #(.AA_CYC(E_AA), .WP_CYC(E_WP)) u_mem (
        .clk_i(clk), .addr_i(mem_addr), .cs1_n_i(cs1_n), .cs2_i(cs2),
        .oe_n_i(oe_n), .we_n_i(we_n), .din_i(dq_o), .din_oe_i(dq_oe),
        .dout_o(dq_i), .viol_o(viol)
    );

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: raises the request at once, holds it until accepted
    task automatic op(input logic wr, input logic [16:0] a, input logic [7:0] d);
        int gap;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        gap = cycle - last_acc;
        check(last_wr ? "R6 write gap" : "R6 read gap",
              gap >= (last_wr ? E_WR_GAP : E_RD_GAP), gap, last_wr ? E_WR_GAP : E_RD_GAP);
        last_acc = cycle; last_wr = wr;
        cur_addr = a; cur_wdata = d;
        if (wr) begin
            shadow[int'(a)] = d;
            writes_issued++;
        end else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : (a[7:0] ^ 8'h5A));
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: run lengths, scoreboard, pulse shapes
    int we_run = 0, oe_run = 0, dq_run = 0;
    int bad_pair = 0, bad_addr = 0, bad_dq = 0, contention = 0;
    logic prev_done = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if ((cs1_n == 1'b0) != (cs2 == 1'b1) || (cs2 == req_ready)) bad_pair++;
        if (!req_ready && mem_addr != cur_addr) bad_addr++;
        if (dq_oe && dq_o != cur_wdata) bad_dq++;
        if (dq_oe && !oe_n) contention++;
        if (!we_n) we_run++;
        else if (we_run != 0) begin check("R4 R8 write pulse length", we_run == E_WP, we_run, E_WP); we_run = 0; end
        if (!oe_n) oe_run++;
        else if (oe_run != 0) begin check("R3 R8 read access length", oe_run == E_AA, oe_run, E_AA); oe_run = 0; end
        if (dq_oe) dq_run++;
        else if (dq_run != 0) begin check("R4 drive span", dq_run == E_WP + 1, dq_run, E_WP + 1); dq_run = 0; end
        if (rd_valid) begin
            if (exp_q.size() == 0) check("R3 unexpected read valid", 1'b0, rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check("R3 read data", rd_data == e, rd_data, e);
            end
        end
        if (wr_done) begin
            done_seen++;
            if (prev_done) check("R7 done pulse width", 1'b0, 2, 1);
        end
        prev_done = wr_done;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 reset select", cs1_n && !cs2, {cs1_n, cs2}, 2'b10);
        check("R1 reset strobes", we_n && oe_n && !dq_oe, {we_n, oe_n, dq_oe}, 3'b110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle handshake", req_ready && !rd_valid && !wr_done,
              {req_ready, rd_valid, wr_done}, 3'b100);
        check("R1 idle select", cs1_n && !cs2 && we_n && oe_n && !dq_oe,
              {cs1_n, cs2, we_n, oe_n, dq_oe}, 5'b10110);
        // writes, including the top address
        op(1'b1, 17'h00010, 8'hA5);
        op(1'b1, 17'h00020, 8'h3C);
        op(1'b1, 17'h1FFFF, 8'h81);
        // back-to-back reads
        op(1'b0, 17'h00010, 8'h00);
        op(1'b0, 17'h1FFFF, 8'h00);
        op(1'b0, 17'h00020, 8'h00);
        // never written location
        op(1'b0, 17'h00045, 8'h00);
        // read-after-write alternation on one address
        op(1'b1, 17'h0007E, 8'hFF);
        op(1'b0, 17'h0007E, 8'h00);
        op(1'b1, 17'h0007E, 8'h00);
        op(1'b0, 17'h0007E, 8'h00);
        // overwrite then read after an idle gap
        repeat (3) @(negedge clk);
        op(1'b1, 17'h00010, 8'h5E);
        repeat (2) @(negedge clk);
        op(1'b0, 17'h00010, 8'h00);
        repeat (10) @(negedge clk);
        check("R3 all reads returned", exp_q.size() == 0, exp_q.size(), 0);
        check("R7 one done per write", done_seen == writes_issued, done_seen, writes_issued);
        check("R2 select pair", bad_pair == 0, bad_pair, 0);
        check("R5 address held", bad_addr == 0, bad_addr, 0);
        check("R4 write data held", bad_dq == 0, bad_dq, 0);
        check("R9 no contention", contention == 0, contention, 0);
        check("R4 R5 memory timing", viol == 0, viol, 0);
        check("R1 back to idle", req_ready && cs1_n && !dq_oe, {req_ready, cs1_n, dq_oe}, 3'b110);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule